// File: doc/BRIEF.md
# Line-Controlled Asynchronous Character Framer

This block turns bytes into asynchronous serial characters and back again. A single line-control byte sets the character format: the data length, one or two stop bits, and the parity mode (none, odd, even, forced mark or forced space). The chosen mode applies to the transmitter and the receiver alike. The same byte can hold the transmit line at space to signal a break. Its top bit decides whether host offsets 0 and 1 reach the data path or the two bytes of the baud divisor.

Both directions run on a tick produced by dividing the system clock by the programmed divisor. Each serial bit lasts sixteen ticks. The transmitter sends a low start bit, then the data bits with the least significant bit first, then the optional parity bit, then the high stop bits. The receiver starts on a falling edge of the line and confirms the start bit at its middle. It then samples every later bit at mid-bit. With each character it delivers a one-cycle strobe, together with parity-error and framing-error flags.

Top module: `lcr_uart_framer`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1, the line-control byte reads 0x00 (five data bits, one stop bit, no parity, odd-parity selection, no break, data path selected) and the divisor reads 0.
- R2: Offset 3 holds the line-control byte and can be read back. Bit 7 set routes offset 0 to divisor bits 7:0 and offset 1 to divisor bits 15:8, for both read and write. Bit 7 clear makes a write to offset 0 a transmit byte and a read of offset 0 the last received byte. With bit 7 clear, writes to offset 1 are ignored and offset 1 reads 0x00.
- R3: A character is sent as a start bit at 0, then the data bits LSB first, then the optional parity bit, then the stop bits at 1. Control bits 1:0 give 5, 6, 7 or 8 data bits (code 0 to 3). Control bit 2 gives one stop bit (0) or two (1). Each bit lasts 16 ticks.
- R4: With control bit 3 at 0, no parity bit is sent and no parity error is flagged, whatever bits 5:4 hold.
- R5: With bit 3 at 1 and bit 5 at 0, bit 4 at 0 selects odd parity and bit 4 at 1 selects even parity. The count is over the data bits plus the parity bit.
- R6: With bits 3 and 5 at 1, the parity bit is 1 when bit 4 is 0 and 0 when bit 4 is 1. The receiver expects the same value.
- R7: With control bit 6 at 1, `txd` is 0 from the cycle after the write until the bit is cleared. The line level returns one cycle after the clear.
- R8: For a divisor N of 1 or more, one tick occurs every N clocks, so a bit lasts 16·N clocks. With a divisor of 0 there are no ticks and a character in progress does not advance.
- R9: `tx_ready` falls in the cycle after an accepted transmit write. It stays low until the last stop bit ends. A transmit write made while it is low is ignored.
- R10: The receiver starts on a falling edge of `rxd` and confirms the start bit 8 ticks later. It then samples each later bit 16 ticks apart. At the first stop-bit sample it pulses `rx_valid` for one cycle and presents the byte on `rx_data`. If the start bit is no longer low at the confirming sample, nothing is received.
- R11: `rx_parity_err` pulses with `rx_valid` when parity is enabled and the received parity bit differs from the expected value.
- R12: `rx_frame_err` pulses with `rx_valid` when the first stop bit is sampled at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register offset for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| txd | output | 1 | Serial transmit line |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rxd | input | 1 | Serial receive line |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| rx_data | output | 8 | Last received byte, right-aligned |
| rx_parity_err | output | 1 | Parity mismatch, with `rx_valid` |
| rx_frame_err | output | 1 | Stop bit sampled low, with `rx_valid` |

## Verification
The transmit line is registered, so with divisor 1 each bit k of an accepted character is visible from cycle 16k+1 to 16k+16 after the write edge, and `tx_ready` comes back exactly 16 times the bit count after it. The bench predicts the whole waveform and compares it on every clock. On the receive side, with divisor 1, the strobe is due exactly 9+16·(data bits + parity bits + 1) cycles after the start edge is driven, and every cycle of the frame is checked against that single expected position. Break, divisor halt and bit length under divisor 2 are checked against counts of whole cycles measured on `txd`.

// File: rtl/lcr_framer_pkg.sv
package lcr_framer_pkg;

   // line-control byte, MSB first: bit7 divisor access ... bits1:0 length
   typedef struct packed {
      logic       dlab;      // 7: offsets 0/1 reach divisor
      logic       brk;       // 6: force line to space
      logic       stick;     // 5: forced parity
      logic       even;      // 4: even / force-zero selection
      logic       par_en;    // 3: parity bit present
      logic       two_stop;  // 2: two stop bits
      logic [1:0] wlen;      // 1:0: 5..8 data bits
   } lcr_t;

   function automatic logic [3:0] data_len(input logic [1:0] wlen);
      return 4'd5 + {2'b00, wlen};
   endfunction

   function automatic logic [7:0] len_mask(input logic [1:0] wlen);
      return 8'hFF >> (2'd3 - wlen);
   endfunction

   function automatic logic parity_of(input logic [7:0] d, input lcr_t c);
      logic x;
      x = ^(d & len_mask(c.wlen));
      if (c.stick) return ~c.even;
      return c.even ? x : ~x;
   endfunction

endpackage

// File: rtl/lcr_baud_tick.sv
module lcr_baud_tick #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic             at_end;

   assign at_end = (cnt >= div - DIV_W'(1));
   assign tick   = (div != '0) && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (div == '0)   cnt <= '0;
      else if (at_end)      cnt <= '0;
      else                  cnt <= cnt + DIV_W'(1);
   end
endmodule

// File: rtl/lcr_tx.sv
module lcr_tx
   import lcr_framer_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  lcr_t       cfg,
   input  logic       load,
   input  logic [7:0] load_data,
   output logic       ready,
   output logic       txd
);
   localparam int FRAME_W = 12;
   localparam int CW      = $clog2(OVS);

   logic [FRAME_W-1:0] frame, asm_frame;
   logic [3:0]         left, asm_len;
   logic [CW-1:0]      tcnt;
   logic               busy;

   always_comb begin
      int n;
      n = int'(data_len(cfg.wlen));
      asm_frame    = '1;
      asm_frame[0] = 1'b0;
      for (int i = 0; i < 8; i++)
         if (i < n) asm_frame[1+i] = load_data[i];
      if (cfg.par_en) asm_frame[1+n] = parity_of(load_data, cfg);
      asm_len = 4'(2 + n + int'(cfg.par_en) + int'(cfg.two_stop));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         frame <= '1;
         left  <= '0;
         tcnt  <= '0;
      end else if (load && !busy) begin
         busy  <= 1'b1;
         frame <= asm_frame;
         left  <= asm_len;
         tcnt  <= '0;
      end else if (busy && tick) begin
         if (tcnt == CW'(OVS-1)) begin
            tcnt  <= '0;
            frame <= {1'b1, frame[FRAME_W-1:1]};
            left  <= left - 4'd1;
            if (left == 4'd1) busy <= 1'b0;
         end else begin
            tcnt <= tcnt + CW'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       txd <= 1'b1;
      else if (cfg.brk) txd <= 1'b0;
      else              txd <= busy ? frame[0] : 1'b1;
   end

   assign ready = !busy;
endmodule

// File: rtl/lcr_rx.sv
module lcr_rx
   import lcr_framer_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  lcr_t       cfg,
   input  logic       line,
   output logic       valid,
   output logic [7:0] data,
   output logic       perr,
   output logic       ferr
);
   localparam int CW   = $clog2(OVS);
   localparam int HALF = OVS / 2;

   typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_state_t;

   rx_state_t     st;
   logic          prev, pbit;
   logic [CW-1:0] tcnt;
   logic [2:0]    bcnt;
   logic [7:0]    sh, aligned;
   logic [3:0]    n;
   logic          bit_end;

   assign n       = data_len(cfg.wlen);
   assign aligned = sh >> (4'd8 - n);
   assign bit_end = tick && (tcnt == CW'(OVS-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= S_IDLE;
         prev  <= 1'b1;
         pbit  <= 1'b0;
         tcnt  <= '0;
         bcnt  <= '0;
         sh    <= '0;
         data  <= '0;
         valid <= 1'b0;
         perr  <= 1'b0;
         ferr  <= 1'b0;
      end else begin
         prev  <= line;
         valid <= 1'b0;
         perr  <= 1'b0;
         ferr  <= 1'b0;
         if (tick && !bit_end && st != S_IDLE) tcnt <= tcnt + CW'(1);
         unique case (st)
            S_IDLE: if (prev && !line) begin
               st   <= S_START;
               tcnt <= '0;
            end
            S_START: if (tick && tcnt == CW'(HALF-1)) begin
               tcnt <= '0;
               bcnt <= '0;
               st   <= line ? S_IDLE : S_DATA;
            end
            S_DATA: if (bit_end) begin
               tcnt <= '0;
               sh   <= {line, sh[7:1]};
               if ({1'b0, bcnt} == n - 4'd1) st <= cfg.par_en ? S_PAR : S_STOP;
               else                          bcnt <= bcnt + 3'd1;
            end
            S_PAR: if (bit_end) begin
               tcnt <= '0;
               pbit <= line;
               st   <= S_STOP;
            end
            S_STOP: if (bit_end) begin
               tcnt  <= '0;
               st    <= S_IDLE;
               valid <= 1'b1;
               data  <= aligned;
               ferr  <= !line;
               perr  <= cfg.par_en && (pbit != parity_of(aligned, cfg));
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lcr_uart_framer.sv
module lcr_uart_framer
   import lcr_framer_pkg::*;
#(
   parameter int DIV_W   = 16,
   parameter int OVS     = 16,
   parameter int RX_SYNC = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] addr,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   output logic       txd,
   output logic       tx_ready,
   input  logic       rxd,
   output logic       rx_valid,
   output logic [7:0] rx_data,
   output logic       rx_parity_err,
   output logic       rx_frame_err
);
   localparam logic [1:0] OFS_LO  = 2'd0;
   localparam logic [1:0] OFS_HI  = 2'd1;
   localparam logic [1:0] OFS_LCR = 2'd3;
   localparam int         HI_W    = DIV_W - 8;

   generate
      if (DIV_W < 9 || DIV_W > 16) begin : g_bad_div
         $error("DIV_W must lie in 9..16");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
   endgenerate

   lcr_t             lcr_q;
   logic [DIV_W-1:0] div_q;
   logic [15:0]      div_pad;
   logic             baud_tick, tx_load, rx_line;

   assign div_pad = 16'(div_q);
   assign tx_load = wr_en && addr == OFS_LO && !lcr_q.dlab;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcr_q <= '0;
         div_q <= '0;
      end else if (wr_en) begin
         if (addr == OFS_LCR)                lcr_q <= lcr_t'(wr_data);
         if (addr == OFS_LO && lcr_q.dlab)   div_q[7:0] <= wr_data;
         if (addr == OFS_HI && lcr_q.dlab)   div_q[DIV_W-1:8] <= wr_data[HI_W-1:0];
      end
   end

   always_comb begin
      unique case (addr)
         OFS_LO:  rd_data = lcr_q.dlab ? div_pad[7:0]  : rx_data;
         OFS_HI:  rd_data = lcr_q.dlab ? div_pad[15:8] : 8'h00;
         OFS_LCR: rd_data = lcr_q;
         default: rd_data = 8'h00;
      endcase
   end

   generate
      if (RX_SYNC == 0) begin : g_rx_direct
         assign rx_line = rxd;
      end else begin : g_rx_sync
         logic [RX_SYNC-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[RX_SYNC-2:0], rxd} ;
         end
         assign rx_line = sync_q[RX_SYNC-1];
      end
   endgenerate

   lcr_baud_tick #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .div(div_q), .tick(baud_tick)
   );

   lcr_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .cfg(lcr_q),
      .load(tx_load), .load_data(wr_data), .ready(tx_ready), .txd(txd)
   );

   lcr_rx #(.OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .cfg(lcr_q), .line(rx_line),
      .valid(rx_valid), .data(rx_data), .perr(rx_parity_err), .ferr(rx_frame_err)
   );
endmodule

// File: rtl/lcr_framer_checker.sv
module lcr_framer_checker
   import lcr_framer_pkg::*;
#(
   parameter int DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       addr,
   input lcr_t             lcr,
   input logic [DIV_W-1:0] div,
   input logic             tick,
   input logic             txd,
   input logic             tx_ready,
   input logic             rx_valid,
   input logic             rx_parity_err,
   input logic             rx_frame_err
);
   assert_break_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lcr.brk |=> !txd);

   assert_idle_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready && !lcr.brk |=> txd);

   assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && addr == 2'd0 && !lcr.dlab && tx_ready |=> !tx_ready);

   assert_tick_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      div == '0 |-> !tick);

   assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_perr_qualified_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_parity_err |-> rx_valid && $past(lcr.par_en));

   assert_ferr_qualified_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rx_frame_err |-> rx_valid);
endmodule

bind lcr_uart_framer lcr_framer_checker #(.DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .lcr(lcr_q),
   .div(div_q), .tick(baud_tick), .txd(txd), .tx_ready(tx_ready),
   .rx_valid(rx_valid), .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
);

// File: tb/lcr_uart_framer_bench.sv
module lcr_uart_framer_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       txd, tx_ready;
   logic       rxd = 1'b1;
   logic       rx_valid, rx_parity_err, rx_frame_err;
   logic [7:0] rx_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lcr_uart_framer u_lcr_uart_framer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .txd(txd), .tx_ready(tx_ready), .rxd(rxd),
      .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      addr = a;
      #1 v = rd_data;
   endtask

   function automatic logic model_par(input logic [7:0] d, input logic [7:0] c);
      int ones = 0;
      for (int i = 0; i < 5 + int'(c[1:0]); i++) ones += int'(d[i]);
      if (c[5]) return ~c[4];
      if (c[4]) return logic'(ones % 2);
      return (ones % 2) == 0;
   endfunction

   function automatic int build(input logic [7:0] d, input logic [7:0] c,
                                output logic [11:0] b);
      int n   = 5 + int'(c[1:0]);
      int idx;
      b = '1;
      b[0] = 1'b0;
      for (int i = 0; i < n; i++) b[1+i] = d[i];
      idx = 1 + n;
      if (c[3]) begin b[idx] = model_par(d, c); idx++; end
      return idx + 1 + int'(c[2]);
   endfunction

   // R3 R4 R5 R6 R9: whole waveform compared every cycle, divisor 1
   task automatic tx_frame(input string req, input logic [7:0] c, input logic [7:0] d);
      logic [11:0] b;
      int t = build(d, c, b);
      logic e;
      wr(2'd3, c);
      @(negedge clk);
      wr_en = 1'b1; addr = 2'd0; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      for (int j = 0; j <= 16*t + 3; j++) begin
         if (j == 0 || j > 16*t) e = 1'b1;
         else                    e = b[(j-1)/16];
         check(req, $sformatf("txd cycle %0d", j), 32'(txd), 32'(e));
         check("R9", $sformatf("tx_ready cycle %0d", j), 32'(tx_ready), 32'(j >= 16*t));
         if (j == 20) begin wr_en = 1'b1; addr = 2'd0; wr_data = ~d; end
         if (j == 21) wr_en = 1'b0;
         @(negedge clk);
      end
   endtask

   // R10 R11 R12: strobe position checked every cycle, divisor 1
   task automatic rx_frame(input string req, input logic [7:0] c, input logic [7:0] d,
                           input bit flip_par, input logic stop_v,
                           input logic exp_pe, input logic exp_fe);
      logic [11:0] b;
      int t = build(d, c, b);
      int n = 5 + int'(c[1:0]);
      int p = int'(c[3]);
      int due = 9 + 16*(n + p + 1);
      logic [7:0] m = 8'hFF >> (8 - n);
      if (flip_par && p == 1) b[1+n] = ~b[1+n];
      b[1+n+p] = stop_v;
      wr(2'd3, c);
      for (int j = 0; j <= 16*t + 15; j++) begin
         check(req, $sformatf("rx_valid cycle %0d", j), 32'(rx_valid), 32'(j == due));
         if (j == due) begin
            check(req, "rx_data", 32'(rx_data), 32'(d & m));
            check("R11", "rx_parity_err", 32'(rx_parity_err), 32'(exp_pe));
            check("R12", "rx_frame_err", 32'(rx_frame_err), 32'(exp_fe));
         end
         rxd = (j < 16*t) ? b[j/16] : 1'b1;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] v;
      int cnt;
      bit seen;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1", "txd", 32'(txd), 32'd1);
      check("R1", "tx_ready", 32'(tx_ready), 32'd1);
      rd(2'd3, v); check("R1", "lcr", 32'(v), 32'h00);

      // R2 divisor latch routing
      wr(2'd3, 8'h80);
      rd(2'd0, v); check("R1", "div lo", 32'(v), 32'h00);
      rd(2'd1, v); check("R1", "div hi", 32'(v), 32'h00);
      wr(2'd0, 8'h34); wr(2'd1, 8'h12);
      rd(2'd0, v); check("R2", "div lo rb", 32'(v), 32'h34);
      rd(2'd1, v); check("R2", "div hi rb", 32'(v), 32'h12);
      rd(2'd3, v); check("R2", "lcr rb", 32'(v), 32'h80);
      wr(2'd0, 8'h01); wr(2'd1, 8'h00);
      wr(2'd3, 8'h03);
      check("R2", "no tx from divisor writes", 32'(tx_ready), 32'd1);
      wr(2'd1, 8'h77);
      rd(2'd1, v); check("R2", "offset1 data path", 32'(v), 32'h00);
      wr(2'd3, 8'h83);
      rd(2'd1, v); check("R2", "div hi untouched", 32'(v), 32'h00);
      rd(2'd0, v); check("R2", "div lo kept", 32'(v), 32'h01);

      // transmit formats, write during busy injected at cycle 20
      tx_frame("R3", 8'h03, 8'hA5);
      tx_frame("R3", 8'h00, 8'hFF);
      tx_frame("R3", 8'h07, 8'h3C);
      tx_frame("R5", 8'h0B, 8'h37);
      tx_frame("R5", 8'h1B, 8'h37);
      tx_frame("R5", 8'h0A, 8'h41);
      tx_frame("R6", 8'h2B, 8'h00);
      tx_frame("R6", 8'h3B, 8'hFF);
      tx_frame("R4", 8'h33, 8'h96);

      // R7 break
      wr(2'd3, 8'h43);
      check("R7", "break pre-edge", 32'(txd), 32'd1);
      cnt = 0;
      for (int j = 0; j < 40; j++) begin @(negedge clk); cnt += int'(txd); end
      check("R7", "break held", 32'(cnt), 32'd0);
      wr(2'd3, 8'h03);
      @(negedge clk);
      check("R7", "break released", 32'(txd), 32'd1);

      // R8 divisor 2: one bit is 32 clocks
      wr(2'd3, 8'h83); wr(2'd0, 8'h02); wr(2'd3, 8'h03);
      wr(2'd0, 8'hAA);
      while (txd !== 1'b0) @(negedge clk);
      while (txd !== 1'b1) @(negedge clk);
      cnt = 0;
      while (txd === 1'b1) begin cnt++; @(negedge clk); end
      check("R8", "bit length div2", 32'(cnt), 32'd32);
      while (tx_ready !== 1'b1) @(negedge clk);

      // R8 divisor 0 halts
      wr(2'd3, 8'h83); wr(2'd0, 8'h00); wr(2'd3, 8'h03);
      wr(2'd0, 8'h55);
      cnt = 0;
      for (int j = 0; j < 100; j++) begin
         @(negedge clk);
         cnt += int'(tx_ready) + int'(txd);
      end
      check("R8", "halted at start bit", 32'(cnt), 32'd0);
      wr(2'd3, 8'h83); wr(2'd0, 8'h01); wr(2'd3, 8'h03);
      while (tx_ready !== 1'b1) @(negedge clk);
      repeat (4) @(negedge clk);

      // receiver
      rx_frame("R10", 8'h03, 8'h5A, 0, 1'b1, 1'b0, 1'b0);
      rd(2'd0, v); check("R2", "rx byte via offset0", 32'(v), 32'h5A);
      rx_frame("R11", 8'h0B, 8'hC3, 0, 1'b1, 1'b0, 1'b0);
      rx_frame("R11", 8'h0B, 8'hC3, 1, 1'b1, 1'b1, 1'b0);
      rx_frame("R11", 8'h1A, 8'h15, 1, 1'b1, 1'b1, 1'b0);
      rx_frame("R6", 8'h2B, 8'h81, 0, 1'b1, 1'b0, 1'b0);
      rx_frame("R6", 8'h3B, 8'h81, 1, 1'b1, 1'b1, 1'b0);
      rx_frame("R4", 8'h33, 8'h7E, 0, 1'b1, 1'b0, 1'b0);
      rx_frame("R12", 8'h03, 8'h99, 0, 1'b0, 1'b0, 1'b1);
      rx_frame("R10", 8'h00, 8'h13, 0, 1'b1, 1'b0, 1'b0);

      // R10 false start
      seen = 0;
      rxd = 1'b0;
      repeat (5) @(negedge clk);
      rxd = 1'b1;
      for (int j = 0; j < 300; j++) begin @(negedge clk); if (rx_valid) seen = 1; end
      check("R10", "false start ignored", 32'(seen), 32'd0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule